// File: doc/BRIEF.md
# LIN Wake-up Request Transmitter

This block puts a LIN wake-up pulse on the bus. It sends one fixed UART character whose low-order bits, together with the start bit, hold the line dominant for a set number of bit times. The character is built into the block and depends on the protocol version. A version-2.0 request gives five dominant bit times. At any baud rate from 1 to 20 kbit/s, that lands inside the 250 µs to 5 ms wake-up window. A version-1.3 request gives eight dominant bit times.

Software starts a request with a one-cycle strobe and chooses the version with a mode bit. An external baud generator supplies a one-cycle tick for each bit period. The block raises `busy_o` while the character is on the line. When the stop bit has gone out, it sets a sticky completion flag, and a status-reset strobe clears that flag.

Top module: `lin_wakeup_tx`

## Requirements
- R1: After reset, `txd_o` is 1 (recessive), `busy_o` is 0 and `done_o` is 0.
- R2: With `mode_i` = 0 (version 2.0), the data byte sent is 0xF0. This gives exactly 5 consecutive dominant (0) bit times, counting the start bit.
- R3: With `mode_i` = 1 (version 1.3), the data byte sent is 0x80. This gives exactly 8 consecutive dominant bit times, counting the start bit.
- R4: A frame is sent in this order: one start bit of 0, then 8 data bits with the LSB first, then one stop bit of 1. The first tick after acceptance puts the start bit on `txd_o`, and each later tick moves to the next bit. `txd_o` never changes in a cycle that follows a cycle without a tick.
- R5: A `start_i` pulse while `busy_o` is 0 is accepted, and `busy_o` is 1 from the next cycle. `busy_o` stays 1 until the 11th tick after acceptance, which ends the stop bit and drops `busy_o`.
- R6: A `start_i` pulse while `busy_o` is 1 is ignored. The frame on the line is not changed, and no second frame follows.
- R7: `mode_i` is sampled only when a start is accepted. Changing it during a transfer does not change the character being sent.
- R8: `done_o` rises in the same cycle that `busy_o` falls. It then stays 1 for as long as no `status_clr_i` arrives.
- R9: `status_clr_i` clears `done_o` in the next cycle. If a clear arrives in the cycle the transfer completes, completion wins and `done_o` stays 1.
- R10: `txd_o` is 1 whenever `busy_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle wake-up request strobe |
| mode_i | input | 1 | Version select: 0 gives 5 dominant bits, 1 gives 8 |
| bit_tick_i | input | 1 | One-cycle pulse per bit period |
| status_clr_i | input | 1 | One-cycle strobe that clears `done_o` |
| txd_o | output | 1 | Serial line, 1 = recessive |
| busy_o | output | 1 | High while a frame is being sent |
| done_o | output | 1 | Sticky transfer-complete flag |

## Verification
The bench sends the frame in both modes and checks every bit against a frame it builds itself. Each check also counts the run of leading dominant bits, so it can tell the 5-bit pattern from the 8-bit pattern and catch a change of bit order. Three more sequences test that state is held during a transfer: a start request in mid-frame, a mode flip in mid-frame, and ticks spaced with idle cycles. Each one fails if the block reloads or resamples. Clear strobes are sent on their own and in the completion cycle, which separates clear-wins behaviour from set-wins behaviour.

// File: rtl/lin_wkup_pkg.sv
`timescale 1ns/1ps
package lin_wkup_pkg;
  typedef enum logic {
    VER_20 = 1'b0,
    VER_13 = 1'b1
  } lin_ver_e;

  localparam int unsigned DOM_BITS_20 = 5;
  localparam int unsigned DOM_BITS_13 = 8;
endpackage

// File: rtl/lin_wkup_char_sel.sv
`timescale 1ns/1ps
// Builds the wake-up byte: the low (dom-1) bits are 0 and the rest are 1.
module lin_wkup_char_sel
  import lin_wkup_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8,
  parameter int unsigned DOM_A     = DOM_BITS_20,
  parameter int unsigned DOM_B     = DOM_BITS_13
) (
  input  lin_ver_e              ver_i,
  output logic [DATA_BITS-1:0]  char_o
);
  localparam int unsigned ZEROS_A = DOM_A - 1;
  localparam int unsigned ZEROS_B = DOM_B - 1;

  logic [DATA_BITS-1:0] pat_a, pat_b;

  for (genvar i = 0; i < DATA_BITS; i++) begin : g_pat
    assign pat_a[i] = (i >= ZEROS_A);
    assign pat_b[i] = (i >= ZEROS_B);
  end

  always_comb begin
    unique case (ver_i)
      VER_20:  char_o = pat_a;
      VER_13:  char_o = pat_b;
      default: char_o = pat_a;
    endcase
  end
endmodule

// File: rtl/lin_wkup_frame_tx.sv
`timescale 1ns/1ps
module lin_wkup_frame_tx #(
  parameter int unsigned DATA_BITS = 8,
  parameter int unsigned STOP_BITS = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [DATA_BITS-1:0] char_i,
  input  logic                 tick_i,
  output logic                 txd_o,
  output logic                 busy_o,
  output logic                 fin_o
);
  localparam int unsigned FRAME_BITS = 1 + DATA_BITS + STOP_BITS;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(FRAME_BITS);

  logic [FRAME_BITS-1:0] sr_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  busy_q, txd_q;
  logic                  step, fin;

  assign step = busy_q & tick_i;
  assign fin  = step & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '1;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      txd_q  <= 1'b1;
    end else if (load_i && !busy_q) begin
      sr_q   <= {{STOP_BITS{1'b1}}, char_i, 1'b0};
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (fin) begin
      busy_q <= 1'b0;
      txd_q  <= 1'b1;
      cnt_q  <= '0;
    end else if (step) begin
      txd_q <= sr_q[0];
      sr_q  <= {1'b1, sr_q[FRAME_BITS-1:1]};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign txd_o  = txd_q;
  assign busy_o = busy_q;
  assign fin_o  = fin;
endmodule

// File: rtl/lin_wkup_done_flag.sv
`timescale 1ns/1ps
module lin_wkup_done_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;  // set wins
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/lin_wakeup_tx.sv
`timescale 1ns/1ps
module lin_wakeup_tx
  import lin_wkup_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8,
  parameter int unsigned STOP_BITS = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic mode_i,
  input  logic bit_tick_i,
  input  logic status_clr_i,
  output logic txd_o,
  output logic busy_o,
  output logic done_o
);
  logic [DATA_BITS-1:0] wk_char;
  logic                 fin;
  lin_ver_e             ver;

  assign ver = lin_ver_e'(mode_i);

  lin_wkup_char_sel #(
    .DATA_BITS(DATA_BITS)
  ) u_char (
    .ver_i (ver),
    .char_o(wk_char)
  );

  lin_wkup_frame_tx #(
    .DATA_BITS(DATA_BITS),
    .STOP_BITS(STOP_BITS)
  ) u_frame (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(start_i),
    .char_i(wk_char),
    .tick_i(bit_tick_i),
    .txd_o (txd_o),
    .busy_o(busy_o),
    .fin_o (fin)
  );

  lin_wkup_done_flag u_done (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (fin),
    .clr_i (status_clr_i),
    .flag_o(done_o)
  );
endmodule

// File: rtl/lin_wakeup_tx_chk.sv
`timescale 1ns/1ps
module lin_wakeup_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic mode_i,
  input logic bit_tick_i,
  input logic status_clr_i,
  input logic txd_o,
  input logic busy_o,
  input logic done_o
);
  assert_idle_recessive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> txd_o);

  assert_txd_on_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_tick_i |=> $stable(txd_o));

  assert_busy_from_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o);

  assert_busy_needs_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> !busy_o);

  assert_busy_ends_on_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !bit_tick_i |=> busy_o);

  assert_done_with_busy_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $fell(busy_o));

  assert_done_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !status_clr_i |=> done_o);

  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_clr_i && !busy_o |=> !done_o);
endmodule

bind lin_wakeup_tx lin_wakeup_tx_chk u_chk (.*);

// File: tb/lin_wakeup_tx_bench.sv
`timescale 1ns/1ps
module lin_wakeup_tx_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, mode = 1'b0, tick = 1'b0, clr = 1'b0;
  logic txd, busy, done;
  int   n_chk = 0, n_bad = 0;
  bit   over = 1'b0;

  always #2.5 clk = ~clk;

  lin_wakeup_tx u_lin_wakeup_tx (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .bit_tick_i(tick), .status_clr_i(clr),
    .txd_o(txd), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!over) begin
      over = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic tick_once(input int gap);
    repeat (gap) @(negedge clk);
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic do_start(input logic m);
    @(negedge clk) begin start = 1'b1; mode = m; end
    @(negedge clk) start = 1'b0;
  endtask

  // Plays all 11 ticks; optional disturbances at given tick index
  task automatic run_frame(input string req, input logic [7:0] ch, input int dom,
                           input int gap, input int poke_at, input logic poke_mode,
                           input logic clr_at_end);
    logic [9:0] fr;
    int run;
    bit zero_run;
    fr = {1'b1, ch, 1'b0};
    run = 0; zero_run = 1'b1;
    chk("R5", "busy after start", busy, 1);
    chk("R4", "txd before first tick", txd, 1);
    for (int i = 0; i < 10; i++) begin
      if (i == poke_at) begin
        @(negedge clk) begin start = 1'b1; mode = poke_mode; end
        @(negedge clk) start = 1'b0;
      end
      tick_once(gap);
      chk(req, $sformatf("bit %0d", i), txd, fr[i]);
      if (zero_run && txd == 1'b0) run++; else zero_run = 1'b0;
      chk("R5", $sformatf("busy at bit %0d", i), busy, 1);
    end
    chk(req, "dominant run", run, dom);
    @(negedge clk) begin tick = 1'b1; clr = clr_at_end; end
    @(negedge clk) begin tick = 1'b0; clr = 1'b0; end
    chk("R5", "busy after stop", busy, 0);
    chk("R10", "txd idle after frame", txd, 1);
    chk(clr_at_end ? "R9" : "R8", "done at end", done, 1);
  endtask

  task automatic t_reset();
    chk("R1", "txd", txd, 1);
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
  endtask

  task automatic t_mode20();
    do_start(1'b0);
    run_frame("R2", 8'hF0, 5, 0, -1, 1'b0, 1'b0);
  endtask

  task automatic t_clear();
    repeat (3) @(negedge clk);
    chk("R8", "done sticky", done, 1);
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    chk("R9", "done cleared", done, 0);
  endtask

  task automatic t_mode13_gapped();
    do_start(1'b1);
    mode = 1'b0;  // flip after acceptance
    run_frame("R3", 8'h80, 8, 2, -1, 1'b0, 1'b0);
  endtask

  task automatic t_start_busy();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    do_start(1'b0);
    run_frame("R6", 8'hF0, 5, 0, 3, 1'b1, 1'b0);
    repeat (2) tick_once(0);
    chk("R6", "no second frame busy", busy, 0);
    chk("R6", "no second frame txd", txd, 1);
  endtask

  task automatic t_mode_latch();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    do_start(1'b0);
    run_frame("R7", 8'hF0, 5, 1, 2, 1'b1, 1'b0);
  endtask

  task automatic t_clr_collide();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    chk("R9", "clear before frame", done, 0);
    do_start(1'b1);
    run_frame("R9", 8'h80, 8, 0, -1, 1'b0, 1'b1);
    tick_once(1);
    chk("R10", "txd idle ticks", txd, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_mode20();
    t_clear();
    t_mode13_gapped();
    t_start_busy();
    t_mode_latch();
    t_clr_collide();
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule